// File: doc/BRIEF.md
# Transaction Packet Transmit Framing Checker

This block sits beside a 64-bit valid/ready transmit stream that carries PCI Express transaction layer packets. Each packet is delimited by a start marker and an end marker. Both markers count only on a beat where valid is high. As a packet passes, the checker reads the first header dword and the address-bearing dword. From them it works out how many bus beats the packet has to occupy. It then confirms that the end marker lands on exactly that beat.

A wrong beat count would leave a real transmit path stuck. The checker records this in a sticky length-error flag. When blocking is enabled, it also holds the source's ready low from then on. Framing faults form a second class: a start marker inside an open packet, or valid data outside any packet. These set a separate sticky protocol-error flag. Each packet that closes on the right beat produces a one-cycle pulse. The expected and observed beat counts are visible for debug.

Top module: `tlp_tx_frame_chk`

## Requirements
- R1: A beat is accepted only on a cycle with `tx_valid` and `tx_ready` both high. `obs_beats` holds the number of beats accepted so far in the current or most recent packet, and it does not change across a stalled cycle.
- R2: The expected count is taken from header dword 0 (`tx_data[31:0]` of the first beat) and from address bit 2. Dword 0 fields: bit 30 means a payload is present, bit 29 means a 4-dword header, bits 28:27 equal to 2'b10 mark a message, and bits 9:0 give the payload length, where 0 means 1024. Address bit 2 is `tx_data[2]` of the second beat for a 3-dword header and `tx_data[34]` for a 4-dword header. The first payload dword index is 3 for a 3-dword header with bit 2 set, 4 for a 3-dword header with bit 2 clear, 4 for a 4-dword header with bit 2 clear, 5 for a 4-dword header with bit 2 set, and always 4 for a message. The expected beats are (index + payload dwords + 1) / 2, or 2 when there is no payload. `exp_beats` takes this value the cycle after the second beat is accepted.
- R3: When the end beat is the expected beat, `pkt_ok` is high for exactly the following cycle, and in that cycle `exp_beats` equals `obs_beats`.
- R4: An end beat that comes before the expected beat sets `err_len` in the next cycle, with no `pkt_ok`.
- R5: A beat without an end marker that reaches the expected count sets `err_len` in the next cycle.
- R6: `err_len` and `err_proto` stay high until reset.
- R7: `tx_ready` follows `sink_ready`, except that it is 0 while `block_en` and `err_len` are both high.
- R8: A start beat while a packet is open sets `err_proto` and restarts the count at that beat, so `obs_beats` becomes 1. The restarted packet is then checked normally.
- R9: A valid beat outside any packet, without a start marker, sets `err_proto` and is not counted.
- R10: Packets sent back to back, with a start beat on the cycle right after an end beat, are each checked with no error.
- R11: A start beat that also carries the end marker sets `err_len`.
- R12: After reset the flags and `pkt_ok` are 0, both counts are 0, and `tx_ready` equals `sink_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 64 | Stream data, two dwords per beat |
| tx_sop | input | 1 | First beat of a packet |
| tx_eop | input | 1 | Last beat of a packet |
| tx_valid | input | 1 | Source has a beat |
| sink_ready | input | 1 | Downstream can take a beat |
| block_en | input | 1 | Hold ready low after a length error |
| tx_ready | output | 1 | Ready returned to the source |
| pkt_ok | output | 1 | Pulse: packet closed on the expected beat |
| err_len | output | 1 | Sticky beat-count error |
| err_proto | output | 1 | Sticky framing error |
| exp_beats | output | 11 | Expected beats of the current packet |
| obs_beats | output | 11 | Beats accepted in the current packet |

## Verification
The hardest case to reach is an overrun under blocking. The length error has to fire on a beat that carries no end marker, and from that point the source must see ready stay low while it keeps offering data. The bench drives a header-only packet whose second beat lacks the end marker, with blocking on. It then holds a third beat valid for several cycles and checks that neither the observed count nor ready moves. Stalls in the middle of a packet are made by dropping `sink_ready` while a beat is offered. Each header layout is sent back to back so that the lane-dependent start index is exercised in every combination.

// File: rtl/tlpchk_pkg.sv
package tlpchk_pkg;
  localparam int BEAT_W = 11;
  localparam int LEN_W  = 10;

  typedef struct packed {
    logic             has_data;
    logic             hdr4;
    logic             is_msg;
    logic [LEN_W-1:0] len;
  } hdr_info_t;

  function automatic hdr_info_t parse_dw0(input logic [31:0] dw0);
    hdr_info_t h;
    h.has_data = dw0[30];
    h.hdr4     = dw0[29];
    h.is_msg   = (dw0[28:27] == 2'b10);
    h.len      = dw0[LEN_W-1:0];
    return h;
  endfunction

  // Beats occupied by a packet, given its header and address bit 2.
  function automatic logic [BEAT_W-1:0] beats_for(input hdr_info_t h, input logic a2);
    int first_dw;
    int pay_dw;
    if (!h.has_data) return BEAT_W'(2);
    pay_dw = (h.len == '0) ? (1 << LEN_W) : int'(h.len);
    if (h.is_msg)    first_dw = 4;
    else if (h.hdr4) first_dw = a2 ? 5 : 4;
    else             first_dw = a2 ? 3 : 4;
    return BEAT_W'((first_dw + pay_dw + 1) / 2);
  endfunction
endpackage

// File: rtl/tlpchk_hdr_decode.sv
module tlpchk_hdr_decode
  import tlpchk_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data,
  input  logic              ev_first,
  input  logic              ev_second,
  output logic [BEAT_W-1:0] exp_now,
  output logic [BEAT_W-1:0] exp_q
);
  localparam int UPPER_A2 = 32 + 2;

  hdr_info_t hdr_q;
  logic      a2_bit;
  logic      unused_lanes;

  assign unused_lanes = ^data;
  assign a2_bit  = hdr_q.hdr4 ? data[UPPER_A2] : data[2];
  assign exp_now = beats_for(hdr_q, a2_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_q <= '0;
      exp_q <= '0;
    end else begin
      if (ev_first)  hdr_q <= parse_dw0(data[31:0]);
      if (ev_second) exp_q <= exp_now;
    end
  end

  // R2
  exp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_second |=> (exp_q >= BEAT_W'(2)));
endmodule

// File: rtl/tlpchk_beat_track.sv
module tlpchk_beat_track
  import tlpchk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              sop,
  input  logic              eop,
  input  logic [BEAT_W-1:0] exp_now,
  input  logic [BEAT_W-1:0] exp_q,
  output logic [BEAT_W-1:0] cnt_q,
  output logic              ev_first,
  output logic              ev_second,
  output logic              ev_ok,
  output logic              ev_len,
  output logic              ev_proto
);
  localparam logic [BEAT_W-1:0] CNT_MAX = '1;

  logic              in_pkt_q, bad_q;
  logic              counted, bad_eff, match;
  logic              ev_stray, ev_dup;
  logic [BEAT_W-1:0] cnt_inc, cnt_n, exp_cur;

  always_comb begin
    cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    cnt_n     = sop ? BEAT_W'(1) : cnt_inc;
    exp_cur   = (cnt_n == BEAT_W'(2)) ? exp_now : exp_q;
    match     = (cnt_n == exp_cur);
    counted   = fire & (sop | in_pkt_q);
    bad_eff   = sop ? 1'b0 : bad_q;
    ev_first  = fire & sop;
    ev_second = counted & ~sop & (cnt_q == BEAT_W'(1));
    ev_stray  = fire & ~sop & ~in_pkt_q;
    ev_dup    = fire & sop & in_pkt_q;
    ev_proto  = ev_stray | ev_dup;
    ev_ok     = counted & eop & ~sop & ~bad_eff & match;
    ev_len    = counted & ~bad_eff & (eop ? ~(match & ~sop) : (~sop & match));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      in_pkt_q <= 1'b0;
      bad_q    <= 1'b0;
    end else if (counted) begin
      cnt_q    <= cnt_n;
      in_pkt_q <= ~eop;
      bad_q    <= eop ? 1'b0 : (bad_eff | ev_len);
    end
  end

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(cnt_q));
  // R8
  restart_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dup |=> (cnt_q == BEAT_W'(1)));
  // R11
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire & sop & eop) |-> (ev_len & ~ev_ok));
endmodule

// File: rtl/tlpchk_flags.sv
module tlpchk_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_ok,
  input  logic ev_len,
  input  logic ev_proto,
  input  logic sink_ready,
  input  logic block_en,
  output logic tx_ready,
  output logic pkt_ok,
  output logic err_len,
  output logic err_proto
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_ok    <= 1'b0;
      err_len   <= 1'b0;
      err_proto <= 1'b0;
    end else begin
      pkt_ok    <= ev_ok;
      err_len   <= err_len | ev_len;
      err_proto <= err_proto | ev_proto;
    end
  end

  assign tx_ready = sink_ready & ~(block_en & err_len);

  // R6
  len_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_len |=> err_len);
  // R6
  proto_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_proto |=> err_proto);
  // R7
  block_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (block_en & err_len) |-> !tx_ready);
endmodule

// File: rtl/tlp_tx_frame_chk.sv
module tlp_tx_frame_chk
  import tlpchk_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_sop,
  input  logic              tx_eop,
  input  logic              tx_valid,
  input  logic              sink_ready,
  input  logic              block_en,
  output logic              tx_ready,
  output logic              pkt_ok,
  output logic              err_len,
  output logic              err_proto,
  output logic [BEAT_W-1:0] exp_beats,
  output logic [BEAT_W-1:0] obs_beats
);
  logic              fire;
  logic              ev_first, ev_second, ev_ok, ev_len, ev_proto;
  logic [BEAT_W-1:0] exp_now;

  assign fire = tx_valid & tx_ready;

  tlpchk_hdr_decode #(.DATA_W(DATA_W)) hdr_i (
    .clk(clk), .rst_n(rst_n), .data(tx_data),
    .ev_first(ev_first), .ev_second(ev_second),
    .exp_now(exp_now), .exp_q(exp_beats)
  );

  tlpchk_beat_track trk_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sop(tx_sop), .eop(tx_eop),
    .exp_now(exp_now), .exp_q(exp_beats), .cnt_q(obs_beats),
    .ev_first(ev_first), .ev_second(ev_second), .ev_ok(ev_ok),
    .ev_len(ev_len), .ev_proto(ev_proto)
  );

  tlpchk_flags flg_i (
    .clk(clk), .rst_n(rst_n), .ev_ok(ev_ok), .ev_len(ev_len),
    .ev_proto(ev_proto), .sink_ready(sink_ready), .block_en(block_en),
    .tx_ready(tx_ready), .pkt_ok(pkt_ok), .err_len(err_len),
    .err_proto(err_proto)
  );

  // R3
  ok_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ok |-> (exp_beats == obs_beats));
  // R4
  ok_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ok |-> !ev_len);
endmodule

// File: tb/tlp_tx_frame_chk_tb_top.sv
module tlp_tx_frame_chk_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tx_data = '0;
  logic        tx_sop = 1'b0, tx_eop = 1'b0, tx_valid = 1'b0;
  logic        sink_ready = 1'b1, block_en = 1'b0;
  logic        tx_ready, pkt_ok, err_len, err_proto;
  logic [10:0] exp_beats, obs_beats;

  int total = 0;
  int bad   = 0;
  int expq[$];
  bit done  = 0;

  always #5 clk = ~clk;

  tlp_tx_frame_chk dut_i (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_sop(tx_sop),
    .tx_eop(tx_eop), .tx_valid(tx_valid), .sink_ready(sink_ready),
    .block_en(block_en), .tx_ready(tx_ready), .pkt_ok(pkt_ok),
    .err_len(err_len), .err_proto(err_proto), .exp_beats(exp_beats),
    .obs_beats(obs_beats)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Payload starts on the lane named by address bit 2; messages always at dword 4.
  function automatic int ref_beats(bit hdr4, bit has_data, bit msg, int len, bit a2);
    int start;
    int words;
    if (!has_data) return 2;
    words = (len == 0) ? 1024 : len;
    start = msg ? 4 : (hdr4 ? 4 + int'(a2) : 4 - int'(a2));
    return (start + words + 1) / 2;
  endfunction

  task automatic drive_beat(input logic [63:0] d, input bit s, input bit e);
    bit acc;
    tx_data = d; tx_sop = s; tx_eop = e; tx_valid = 1'b1;
    do begin
      @(negedge clk); acc = tx_ready;
      @(posedge clk); #1;
    end while (!acc);
    tx_valid = 1'b0; tx_sop = 1'b0; tx_eop = 1'b0;
  endtask

  function automatic logic [63:0] beat_word(bit hdr4, bit has_data, bit msg,
                                            int len, bit a2, int i);
    logic [31:0] dw0;
    dw0 = {1'b0, has_data, hdr4, (msg ? 5'b10000 : 5'b00000), 14'h0, 10'(len)};
    if (i == 0) return {32'hCAFE0001, dw0};
    if (i == 1) return hdr4 ? {29'h1234, a2, 2'b00, 32'h0}
                            : {32'hA5A5A5A5, 29'h0777, a2, 2'b00};
    return {32'(i), ~32'(i)};
  endfunction

  task automatic send_pkt(input bit hdr4, input bit has_data, input bit msg,
                          input int len, input bit a2, input int nsent, input bit push);
    int n;
    n = (nsent < 0) ? ref_beats(hdr4, has_data, msg, len, a2) : nsent;
    if (push) expq.push_back(ref_beats(hdr4, has_data, msg, len, a2));
    for (int i = 0; i < n; i++)
      drive_beat(beat_word(hdr4, has_data, msg, len, a2, i), i == 0, i == n - 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tx_valid = 1'b0; tx_sop = 1'b0; tx_eop = 1'b0;
    sink_ready = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    expq.delete();
  endtask

  // Monitor: pops the scoreboard on each completion pulse.
  always @(negedge clk) begin
    if (rst_n && pkt_ok && !done) begin
      if (expq.size() == 0) chk(1'b0, "R3 unexpected pkt_ok", int'(obs_beats), -1);
      else begin
        int e;
        e = expq.pop_front();
        chk(exp_beats == 11'(e), "R2 exp_beats", int'(exp_beats), e);
        chk(obs_beats == 11'(e), "R3 obs_beats", int'(obs_beats), e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R12 reset state
    chk(!err_len && !err_proto && !pkt_ok, "R12 flags", int'(err_len), 0);
    chk(obs_beats == 0 && exp_beats == 0, "R12 counts", int'(obs_beats), 0);
    chk(tx_ready == 1'b1, "R12 ready", int'(tx_ready), 1);
    @(posedge clk); #1;

    // R10 back to back, every layout (R2, R11 message)
    send_pkt(0, 1, 0, 1, 0, -1, 1);
    send_pkt(0, 1, 0, 1, 1, -1, 1);
    send_pkt(1, 1, 0, 2, 0, -1, 1);
    send_pkt(1, 1, 0, 3, 1, -1, 1);
    send_pkt(0, 0, 0, 0, 0, -1, 1);
    send_pkt(1, 0, 0, 0, 1, -1, 1);
    send_pkt(1, 1, 1, 2, 1, -1, 1);
    send_pkt(0, 1, 0, 0, 1, -1, 1);
    repeat (2) @(negedge clk);
    chk(!err_len && !err_proto, "R10 no error", int'(err_len | err_proto), 0);
    chk(expq.size() == 0, "R3 all completed", expq.size(), 0);
    @(posedge clk); #1;

    // R1 stall mid-packet
    expq.push_back(ref_beats(0, 1, 0, 4, 0));
    drive_beat(beat_word(0, 1, 0, 4, 0, 0), 1, 0);
    sink_ready = 1'b0;
    tx_data = beat_word(0, 1, 0, 4, 0, 1); tx_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(obs_beats == 1, "R1 stall hold", int'(obs_beats), 1);
    chk(tx_ready == 1'b0, "R7 ready follows sink", int'(tx_ready), 0);
    @(posedge clk); #1 sink_ready = 1'b1;
    drive_beat(beat_word(0, 1, 0, 4, 0, 1), 0, 0);
    drive_beat(beat_word(0, 1, 0, 4, 0, 2), 0, 0);
    @(negedge clk);
    chk(obs_beats == 3, "R1 count after stall", int'(obs_beats), 3);
    @(posedge clk); #1;
    drive_beat(beat_word(0, 1, 0, 4, 0, 3), 0, 1);
    repeat (2) @(negedge clk);
    chk(!err_len, "R1 stalled packet ok", int'(err_len), 0);

    // R9 stray beat
    do_reset();
    drive_beat(64'h1111, 0, 0);
    @(negedge clk);
    chk(err_proto == 1'b1, "R9 err_proto", int'(err_proto), 1);
    chk(obs_beats == 0, "R9 not counted", int'(obs_beats), 0);
    @(posedge clk); #1;
    send_pkt(0, 1, 0, 2, 1, -1, 1);
    repeat (2) @(negedge clk);
    chk(err_proto == 1'b1 && !err_len, "R6 proto sticky", int'(err_proto), 1);

    // R8 restart inside open packet
    do_reset();
    drive_beat(beat_word(1, 1, 0, 4, 0, 0), 1, 0);
    drive_beat(beat_word(1, 1, 0, 4, 0, 1), 0, 0);
    drive_beat(beat_word(0, 1, 0, 2, 0, 0), 1, 0);
    @(negedge clk);
    chk(err_proto == 1'b1, "R8 err_proto", int'(err_proto), 1);
    chk(obs_beats == 1, "R8 restart count", int'(obs_beats), 1);
    @(posedge clk); #1;
    expq.push_back(ref_beats(0, 1, 0, 2, 0));
    for (int i = 1; i < 3; i++)
      drive_beat(beat_word(0, 1, 0, 2, 0, i), 0, i == 2);
    repeat (2) @(negedge clk);
    chk(!err_len && expq.size() == 0, "R8 restarted packet ok", int'(err_len), 0);

    // R4 early end, non-blocking
    do_reset();
    send_pkt(0, 1, 0, 4, 0, 2, 0);
    @(negedge clk);
    chk(err_len == 1'b1, "R4 err_len", int'(err_len), 1);
    chk(tx_ready == 1'b1, "R7 no block", int'(tx_ready), 1);
    @(posedge clk); #1;
    send_pkt(1, 1, 0, 1, 0, -1, 1);
    repeat (2) @(negedge clk);
    chk(err_len == 1'b1, "R6 len sticky", int'(err_len), 1);

    // R11 single-beat packet
    do_reset();
    drive_beat(beat_word(0, 0, 0, 0, 0, 0), 1, 1);
    @(negedge clk);
    chk(err_len == 1'b1, "R11 err_len", int'(err_len), 1);
    chk(pkt_ok == 1'b0, "R11 no pkt_ok", int'(pkt_ok), 0);

    // R5 overrun with blocking
    do_reset();
    block_en = 1'b1;
    drive_beat(beat_word(0, 0, 0, 0, 0, 0), 1, 0);
    drive_beat(beat_word(0, 0, 0, 0, 0, 1), 0, 0);
    @(negedge clk);
    chk(err_len == 1'b1, "R5 err_len", int'(err_len), 1);
    chk(tx_ready == 1'b0, "R7 blocked", int'(tx_ready), 0);
    chk(exp_beats == 2 && obs_beats == 2, "R5 counts", int'(obs_beats), 2);
    tx_data = 64'h2222; tx_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(obs_beats == 2 && tx_ready == 1'b0, "R7 stays blocked", int'(obs_beats), 2);
    tx_valid = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule